// File: doc/BRIEF.md
# Registered RISC Integer ALU

This block is the integer execution unit of a small load/store processor. Each cycle it can take one operation: an operation code, a first source word and a second source. The second source is either a full 32-bit register value or a 16-bit immediate that the block sign-extends. One clock edge later it presents a 32-bit result with a valid strobe. It covers wrapping add and subtract, the low word of a product, bitwise AND/OR/XOR, left shift, logical and arithmetic right shift, and three signed tests.

A test never sets condition flags. It writes the word 1 when it holds and the word 0 when it does not, so a following branch can test that result register against zero. Divide has an operation code but no hardware here. The block reports it, and every other undefined code, through a separate `unsupported` output so the pipeline can raise a trap.

Top module: `risc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `unsupported` are all 0 after that edge.
- R2: An operation accepted with `in_valid` high at one rising edge appears on `result`/`unsupported` with `out_valid` high right after that edge. With `in_valid` low, `out_valid` is 0 after the edge.
- R3: When `in_valid` is low at an edge, `result` and `unsupported` keep their previous values, whatever the other inputs carry.
- R4: When `use_lit` is 1, the second operand is `lit` sign-extended to 32 bits and `src_b` is ignored. When `use_lit` is 0, the second operand is `src_b`.
- R5: Code 0 adds and code 1 subtracts (first minus second). Both wrap modulo 2^32.
- R6: Code 2 returns the low 32 bits of the product of the two operands.
- R7: Code 4 tests equality, code 5 tests signed less-than and code 6 tests signed less-or-equal (first against second). The result is 32'd1 when true and 32'd0 when false.
- R8: Code 8 is bitwise AND, code 9 is OR and code 10 is XOR.
- R9: Code 12 shifts the first operand left by the low 5 bits of the second operand, filling with zeros.
- R10: Code 13 shifts right filling with zeros, and code 14 shifts right filling with the sign bit. Both use the low 5 bits of the second operand as the shift amount.
- R11: Code 3 (divide) and the undefined codes 7, 11 and 15 produce `unsupported` = 1 and `result` = 0. Every defined code produces `unsupported` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand, register form |
| use_lit | input | 1 | Take the second operand from `lit` |
| lit | input | 16 | Signed immediate |
| out_valid | output | 1 | `result` holds a new value |
| result | output | 32 | Operation result |
| unsupported | output | 1 | Operation code has no implementation |

## Verification
The bench targets carries and sign. A wrapping add of all-ones plus one must give zero, and a signed compare of -1 against 1 must give 1; an unsigned compare would return 0. Arithmetic and logical right shifts of a word with its top bit set must differ. A shift amount of 33 must act as 1, which catches a design that reads more than five bits. A negative immediate must reach the adder with its upper half filled with ones, which catches zero extension or a stray use of `src_b`. Divide and the undefined codes must raise `unsupported` and give a zero result, and an idle cycle must leave `result` untouched.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN    = 32;
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 4;
    localparam int SHAMT_W = $clog2(XLEN);

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_DIV  = 4'd3,
        OP_CEQ  = 4'd4,
        OP_CLT  = 4'd5,
        OP_CLE  = 4'd6,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_SHL  = 4'd12,
        OP_SHR  = 4'd13,
        OP_SAR  = 4'd14
    } alu_op_e;

    typedef enum logic [2:0] {
        GRP_ARITH,
        GRP_CMP,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_NONE
    } alu_grp_e;

    typedef struct packed {
        logic            bad;
        logic [XLEN-1:0] word;
    } alu_out_t;

    function automatic alu_grp_e op_group(input logic [OPC_W-1:0] code);
        alu_grp_e g;
        case (code)
            OP_ADD, OP_SUB, OP_MUL:          g = GRP_ARITH;
            OP_CEQ, OP_CLT, OP_CLE:          g = GRP_CMP;
            OP_AND, OP_OR, OP_XOR:           g = GRP_LOGIC;
            OP_SHL, OP_SHR, OP_SAR:          g = GRP_SHIFT;
            default:                         g = GRP_NONE;
        endcase
        return g;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0]  reg_b,
    input  logic [IW-1:0] imm,
    input  logic          pick_imm,
    output logic [W-1:0]  opnd_b
);
    logic [W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{(W-IW){imm[IW-1]}}, imm};
        opnd_b  = pick_imm ? imm_ext : reg_b;
    end
endmodule

// File: rtl/alu_arith_cmp.sv
module alu_arith_cmp
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPC_W-1:0] code,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     arith_y,
    output logic [W-1:0]     cmp_y
);
    logic [W-1:0] sum;
    logic [W-1:0] diff;
    logic [W-1:0] prod;
    logic         eq;
    logic         lt;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        prod = a * b;
        eq   = (a == b);
        lt   = ($signed(a) < $signed(b));

        case (code)
            OP_SUB:  arith_y = diff;
            OP_MUL:  arith_y = prod;
            default: arith_y = sum;
        endcase

        cmp_y = '0;
        case (code)
            OP_CEQ:  cmp_y[0] = eq;
            OP_CLT:  cmp_y[0] = lt;
            OP_CLE:  cmp_y[0] = lt | eq;
            default: cmp_y[0] = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
    import alu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [OPC_W-1:0] code,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    output logic [W-1:0]     logic_y,
    output logic [W-1:0]     shift_y
);
    localparam int SW = $clog2(W);

    logic [SW-1:0] amt;
    logic          fill;
    logic [W-1:0]  lstage [SW+1];
    logic [W-1:0]  rstage [SW+1];

    assign amt       = b[SW-1:0];
    assign fill      = (code == OP_SAR) ? a[W-1] : 1'b0;
    assign lstage[0] = a;
    assign rstage[0] = a;

    for (genvar i = 0; i < SW; i++) begin : g_stage
        localparam int D = 1 << i;
        assign lstage[i+1] = amt[i] ? {lstage[i][W-1-D:0], {D{1'b0}}} : lstage[i];
        assign rstage[i+1] = amt[i] ? {{D{fill}}, rstage[i][W-1:D]}   : rstage[i];
    end

    always_comb begin
        case (code)
            OP_OR:   logic_y = a | b;
            OP_XOR:  logic_y = a ^ b;
            default: logic_y = a & b;
        endcase
        shift_y = (code == OP_SHL) ? lstage[SW] : rstage[SW];
    end
endmodule

// File: rtl/risc_alu.sv
module risc_alu
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] op,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic             use_lit,
    input  logic [IW-1:0]    lit,
    output logic             out_valid,
    output logic [W-1:0]     result,
    output logic             unsupported
);
    logic [W-1:0] opnd_b;
    logic [W-1:0] arith_y, cmp_y, logic_y, shift_y;
    logic [W-1:0] next_word;
    logic         next_bad;
    alu_grp_e     grp;

    alu_operand_sel #(.W(W), .IW(IW)) u_sel (
        .reg_b    (src_b),
        .imm      (lit),
        .pick_imm (use_lit),
        .opnd_b   (opnd_b)
    );

    alu_arith_cmp #(.W(W)) u_ac (
        .code    (op),
        .a       (src_a),
        .b       (opnd_b),
        .arith_y (arith_y),
        .cmp_y   (cmp_y)
    );

    alu_logic_shift #(.W(W)) u_ls (
        .code    (op),
        .a       (src_a),
        .b       (opnd_b),
        .logic_y (logic_y),
        .shift_y (shift_y)
    );

    always_comb begin
        grp      = op_group(op);
        next_bad = 1'b0;
        case (grp)
            GRP_ARITH: next_word = arith_y;
            GRP_CMP:   next_word = cmp_y;
            GRP_LOGIC: next_word = logic_y;
            GRP_SHIFT: next_word = shift_y;
            default: begin
                next_word = '0;
                next_bad  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            result      <= '0;
            unsupported <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result      <= next_word;
                unsupported <= next_bad;
            end
        end
    end
endmodule

// File: rtl/risc_alu_checker.sv
module risc_alu_checker #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    op,
    input logic [W-1:0]  src_a,
    input logic [W-1:0]  src_b,
    input logic          use_lit,
    input logic [IW-1:0] lit,
    input logic          out_valid,
    input logic [W-1:0]  result,
    input logic          unsupported
);
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    always @(posedge clk) begin
        if (seen_edge && $past(rst)) begin
            AST_RESET_CLEAR: assert (!out_valid && result == '0 && !unsupported); // R1
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(unsupported))); // R3

    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd4 || op == 4'd5 || op == 4'd6)) |=> (result[W-1:1] == '0)); // R7

    AST_EQ_SELF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd4 && !use_lit && src_a == src_b) |=> (result == 1)); // R7

    AST_UNSUP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 4'd3 || op == 4'd7 || op == 4'd11 || op == 4'd15))
            |=> (unsupported && result == '0)); // R11
endmodule

bind risc_alu risc_alu_checker #(.W(W), .IW(IW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op          (op),
    .src_a       (src_a),
    .src_b       (src_b),
    .use_lit     (use_lit),
    .lit         (lit),
    .out_valid   (out_valid),
    .result      (result),
    .unsupported (unsupported)
);

// File: tb/risc_alu_test.sv
`timescale 1ns/1ps
module risc_alu_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic [31:0] src_a, src_b;
    logic        use_lit;
    logic [15:0] lit;
    logic        out_valid;
    logic [31:0] result;
    logic        unsupported;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    risc_alu uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .op          (op),
        .src_a       (src_a),
        .src_b       (src_b),
        .use_lit     (use_lit),
        .lit         (lit),
        .out_valid   (out_valid),
        .result      (result),
        .unsupported (unsupported)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b,
                         input logic ul, input logic [15:0] imm);
        @(negedge clk);
        in_valid = 1'b1; op = c; src_a = a; src_b = b; use_lit = ul; lit = imm;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic run_reg(input string tag, input logic [3:0] c, input logic [31:0] a,
                           input logic [31:0] b, input logic [31:0] exp);
        issue(c, a, b, 1'b0, 16'h0);
        check({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, result, exp);
        check({tag, " unsup"}, {31'd0, unsupported}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1; op = 4'd0; src_a = 32'd5; src_b = 32'd7;
        use_lit = 1'b0; lit = 16'h0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid", {31'd0, out_valid}, 32'd0);
        check("R1 result", result, 32'd0);
        check("R1 unsupported", {31'd0, unsupported}, 32'd0);
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic t_arith();
        run_reg("R5 add wrap", 4'd0, 32'hFFFF_FFFF, 32'd1, 32'd0);
        run_reg("R5 add", 4'd0, 32'd1000, 32'd234, 32'd1234);
        run_reg("R5 sub wrap", 4'd1, 32'd0, 32'd1, 32'hFFFF_FFFF);
        run_reg("R5 sub order", 4'd1, 32'd10, 32'd3, 32'd7);
        run_reg("R6 mul low", 4'd2, 32'h0001_0000, 32'h0001_0000, 32'd0);
        run_reg("R6 mul neg", 4'd2, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFFD);
        run_reg("R6 mul", 4'd2, 32'd1234, 32'd1000, 32'd1234000);
    endtask

    task automatic t_compare();
        run_reg("R7 eq true", 4'd4, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 32'd1);
        run_reg("R7 eq false", 4'd4, 32'd1, 32'd2, 32'd0);
        run_reg("R7 lt signed", 4'd5, 32'hFFFF_FFFF, 32'd1, 32'd1);
        run_reg("R7 lt reverse", 4'd5, 32'd1, 32'hFFFF_FFFF, 32'd0);
        run_reg("R7 lt equal", 4'd5, 32'd5, 32'd5, 32'd0);
        run_reg("R7 le equal", 4'd6, 32'd5, 32'd5, 32'd1);
        run_reg("R7 le false", 4'd6, 32'd6, 32'd5, 32'd0);
        run_reg("R7 le min", 4'd6, 32'h8000_0000, 32'h7FFF_FFFF, 32'd1);
    endtask

    task automatic t_logic();
        run_reg("R8 and", 4'd8, 32'hF0F0_FF00, 32'hFF00_F0F0, 32'hF000_F000);
        run_reg("R8 or",  4'd9, 32'hF0F0_0000, 32'h0F00_000F, 32'hFFF0_000F);
        run_reg("R8 xor", 4'd10, 32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555);
    endtask

    task automatic t_shift();
        run_reg("R9 shl 33", 4'd12, 32'd1, 32'd33, 32'd2);
        run_reg("R9 shl 31", 4'd12, 32'd3, 32'd31, 32'h8000_0000);
        run_reg("R9 shl 0", 4'd12, 32'h1234_5678, 32'd0, 32'h1234_5678);
        run_reg("R10 shr", 4'd13, 32'h8000_0000, 32'd31, 32'd1);
        run_reg("R10 sar", 4'd14, 32'h8000_0000, 32'd31, 32'hFFFF_FFFF);
        run_reg("R10 sar 4", 4'd14, 32'hF000_00F0, 32'd4, 32'hFF00_000F);
        run_reg("R10 shr 4", 4'd13, 32'hF000_00F0, 32'd4, 32'h0F00_000F);
        run_reg("R10 sar pos", 4'd14, 32'h7000_0000, 32'd36, 32'h0700_0000);
    endtask

    task automatic t_literal();
        issue(4'd0, 32'd1, 32'h0000_1000, 1'b1, 16'hFFFD);
        check("R4 lit neg add", result, 32'hFFFF_FFFE);
        issue(4'd1, 32'd10, 32'hFFFF_FFFF, 1'b1, 16'h0003);
        check("R4 lit sub ignores src_b", result, 32'd7);
        issue(4'd8, 32'hFFFF_FFFF, 32'd0, 1'b1, 16'h8001);
        check("R4 lit and sext", result, 32'hFFFF_8001);
        issue(4'd6, 32'hFFFF_FFFE, 32'd0, 1'b1, 16'hFFFF);
        check("R4 lit le", result, 32'd1);
    endtask

    task automatic t_unsupported();
        issue(4'd3, 32'd100, 32'd5, 1'b0, 16'h0);
        check("R11 div unsup", {31'd0, unsupported}, 32'd1);
        check("R11 div result", result, 32'd0);
        for (int k = 0; k < 3; k++) begin
            logic [3:0] c;
            c = 4'(7 + 4 * k);
            issue(c, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0);
            check("R11 undefined unsup", {31'd0, unsupported}, 32'd1);
            check("R11 undefined result", result, 32'd0);
        end
        run_reg("R11 clears after add", 4'd0, 32'd2, 32'd2, 32'd4);
    endtask

    task automatic t_hold();
        run_reg("R2 before idle", 4'd9, 32'h0000_00F0, 32'h0000_000F, 32'h0000_00FF);
        @(negedge clk);
        in_valid = 1'b0; op = 4'd3; src_a = 32'h1111_1111; src_b = 32'h2222_2222;
        @(posedge clk);
        #1;
        check("R2 idle no valid", {31'd0, out_valid}, 32'd0);
        check("R3 idle result", result, 32'h0000_00FF);
        check("R3 idle unsup", {31'd0, unsupported}, 32'd0);
        @(posedge clk);
        #1;
        check("R3 idle result 2", result, 32'h0000_00FF);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_compare();
        t_logic();
        t_shift();
        t_literal();
        t_unsupported();
        t_hold();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule